// File: doc/BRIEF.md
# Core Test Wrapper Serial Instruction Controller

This block is the serial control layer of a test wrapper placed around an embedded core. A single test clock and an active-low asynchronous reset run every register inside it. A register-select input chooses between the instruction path and the data path. Three separate enables request shift, capture and update operations. One serial input and one serial output carry the scan data. When the select input is high, the instruction shift stage sits between serial in and serial out. When it is low, the data register picked by the active instruction sits there instead. That register is the internal one-bit bypass, the external boundary register, or the external core data register.

The active instruction lives in an update stage held as an enumerated state register. Its states are `M_BYPASS`, `M_EXTEST`, `M_PRELOAD`, `M_CLAMP`, `M_SAFE` and `M_CORETEST`. There is one transition, `T_LOAD`. It fires on a clock edge when the select input and the update enable are both high, and it moves the state to the decode of the shift stage. Reset forces `M_BYPASS`. In every other cycle the state holds, so the modes stay steady while new instruction bits shift through.

The state drives the mode lines for the boundary cells and the core:
- the wrapper output source;
- the core input source;
- the core safe flag.

It also gates the shift, capture and update enables through to the selected external register only.

Top module: `core_wrap_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the state is `M_BYPASS`. `out_src` is 00, `core_in_src` is 0 and `core_safe` is 0.
- R2: With `sel_ir` high, `so` equals the LSB of the instruction shift stage. Each shift moves `si` into the MSB and shifts right, so with a 3-bit register a bit entered on `si` appears on `so` after 3 shifts.
- R3: Capture with `sel_ir` high loads the pattern 01 into the two LSBs of the shift stage and zeros above them. Shifting out therefore yields 1, 0, 0. Capture takes priority over shift.
- R4: The state and all mode outputs change only on an edge where `sel_ir` and `update_en` are both high. Instruction shift and capture leave them unchanged.
- R5: The bypass register is one bit. With `sel_ir` low, a shift loads `si` into it and a capture loads 0. In bypass-routed states, `so` equals its value.
- R6: Code 001 (external test): `so` follows `bnd_so` and the boundary enables are forwarded. `out_src`=01 (boundary register value), `core_safe`=1, `core_in_src`=0.
- R7: Code 010 (preload): `so` follows `bnd_so` and the boundary enables, including update, are forwarded. `out_src`=00, `core_in_src`=0, `core_safe`=0.
- R8: Code 011 (clamp): `so` follows the bypass register and `out_src`=01. `core_safe`=1. `bnd_update`, `bnd_shift` and `bnd_capture` stay 0, so the boundary outputs stay frozen.
- R9: Code 100 (safe state): `so` follows the bypass register, `out_src`=10 (built-in safe values) and `core_safe`=1. No boundary enable is forwarded.
- R10: Code 101 (core test): `so` follows `cdr_so` and only the core data register enables are forwarded. `core_in_src`=1 (boundary drives core inputs), `out_src`=10 and `core_safe`=0.
- R11: Code 000 and the unused codes 110 and 111 decode to bypass. Bypass routes the bypass register, forwards no enables, and gives `out_src`=00, `core_in_src`=0, `core_safe`=0.
- R12: With `sel_ir` high, none of the six external register enables is asserted. At most one of the two external registers is ever selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Wrapper test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_ir | input | 1 | High: instruction path; low: data path |
| shift_en | input | 1 | Shift request |
| capture_en | input | 1 | Capture request |
| update_en | input | 1 | Update request |
| si | input | 1 | Serial input |
| so | output | 1 | Serial output |
| bnd_so | input | 1 | Serial return from the boundary register |
| cdr_so | input | 1 | Serial return from the core data register |
| bnd_shift | output | 1 | Shift enable to boundary register |
| bnd_capture | output | 1 | Capture enable to boundary register |
| bnd_update | output | 1 | Update enable to boundary update stage |
| cdr_shift | output | 1 | Shift enable to core data register |
| cdr_capture | output | 1 | Capture enable to core data register |
| cdr_update | output | 1 | Update enable to core data register |
| out_src | output | 2 | Wrapper output source: 00 functional, 01 boundary value, 10 safe value |
| core_in_src | output | 1 | 0 functional core inputs, 1 boundary-driven |
| core_safe | output | 1 | Core held in safe mode |

## Verification
All eight instruction codes are swept, including the two unused ones. Each is loaded through a capture followed by three shifts and an update. The captured 1,0,0 sequence on `so` confirms both the capture pattern and the shift direction. Mode outputs are checked on every instruction-path cycle, which separates a correct update stage from one that follows the shift stage.

For each code, the data path is probed three ways. Alternating values are placed on `bnd_so` and `cdr_so` with the bypass bit held opposite, so each possible route gives a different `so`. Each enable is raised alone to show which external register receives it. A capture through the bypass register shows the 0 load. A separate shift-through of an arbitrary bit stream with `sel_ir` high confirms the three-cycle delay.

// File: rtl/wrap_ctl_pkg.sv
package wrap_ctl_pkg;

    typedef enum logic [2:0] {
        M_BYPASS   = 3'd0,
        M_EXTEST   = 3'd1,
        M_PRELOAD  = 3'd2,
        M_CLAMP    = 3'd3,
        M_SAFE     = 3'd4,
        M_CORETEST = 3'd5
    } wmode_e;

    typedef enum logic [1:0] {
        RT_BYP = 2'd0,
        RT_BND = 2'd1,
        RT_CDR = 2'd2
    } route_e;

    localparam logic [1:0] OSRC_FUNC = 2'b00;
    localparam logic [1:0] OSRC_BND  = 2'b01;
    localparam logic [1:0] OSRC_SAFE = 2'b10;

    localparam int unsigned CODE_BYPASS   = 0;
    localparam int unsigned CODE_EXTEST   = 1;
    localparam int unsigned CODE_PRELOAD  = 2;
    localparam int unsigned CODE_CLAMP    = 3;
    localparam int unsigned CODE_SAFE     = 4;
    localparam int unsigned CODE_CORETEST = 5;

endpackage

// File: rtl/wrap_ir_reg.sv
module wrap_ir_reg #(
    parameter int unsigned IR_W = 3
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            sel_ir,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            si,
    output logic [IR_W-1:0] sr_q,
    output logic            sr_lsb
);

    localparam logic [IR_W-1:0] CAP_PATTERN = IR_W'(2'b01);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sel_ir && capture_en) begin
            sr_q <= CAP_PATTERN;
        end else if (sel_ir && shift_en) begin
            sr_q <= {si, sr_q[IR_W-1:1]};
        end
    end

    assign sr_lsb = sr_q[0];

    // R3: capture leaves 01 in the low bits
    p_capture_pattern_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_ir && capture_en) |=> (sr_q[1:0] == 2'b01));

    // R2: a shift moves the serial input into the MSB
    p_shift_in_msb_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_ir && shift_en && !capture_en) |=> (sr_q[IR_W-1] == $past(si)));

endmodule

// File: rtl/wrap_bypass_reg.sv
module wrap_bypass_reg (
    input  logic tck,
    input  logic rst_n,
    input  logic dr_path,
    input  logic shift_en,
    input  logic capture_en,
    input  logic si,
    output logic q
);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (dr_path && capture_en) begin
            q <= 1'b0;
        end else if (dr_path && shift_en) begin
            q <= si;
        end
    end

    // R5: one-bit delay from serial in
    p_bypass_delay_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_path && shift_en && !capture_en) |=> (q == $past(si)));

    // R5: capture clears the bypass bit
    p_bypass_capture_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_path && capture_en) |=> !q);

endmodule

// File: rtl/wrap_mode_fsm.sv
module wrap_mode_fsm
    import wrap_ctl_pkg::*;
#(
    parameter int unsigned IR_W = 3
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            sel_ir,
    input  logic            update_en,
    input  logic            shift_en,
    input  logic [IR_W-1:0] code,
    output wmode_e          state,
    output route_e          route,
    output logic [1:0]      out_src,
    output logic            core_in_src,
    output logic            core_safe,
    output logic            bnd_upd_ok
);

    wmode_e next_state;

    // decode of the shift stage, used by transition T_LOAD
    always_comb begin
        if      (code == IR_W'(CODE_EXTEST))   next_state = M_EXTEST;
        else if (code == IR_W'(CODE_PRELOAD))  next_state = M_PRELOAD;
        else if (code == IR_W'(CODE_CLAMP))    next_state = M_CLAMP;
        else if (code == IR_W'(CODE_SAFE))     next_state = M_SAFE;
        else if (code == IR_W'(CODE_CORETEST)) next_state = M_CORETEST;
        else                                   next_state = M_BYPASS;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_BYPASS;
        end else if (sel_ir && update_en) begin
            state <= next_state;
        end
    end

    always_comb begin
        route       = RT_BYP;
        out_src     = OSRC_FUNC;
        core_in_src = 1'b0;
        core_safe   = 1'b0;
        bnd_upd_ok  = 1'b0;
        unique case (state)
            M_BYPASS: begin
            end
            M_EXTEST: begin
                route      = RT_BND;
                out_src    = OSRC_BND;
                core_safe  = 1'b1;
                bnd_upd_ok = 1'b1;
            end
            M_PRELOAD: begin
                route      = RT_BND;
                bnd_upd_ok = 1'b1;
            end
            M_CLAMP: begin
                out_src   = OSRC_BND;
                core_safe = 1'b1;
            end
            M_SAFE: begin
                out_src   = OSRC_SAFE;
                core_safe = 1'b1;
            end
            M_CORETEST: begin
                route       = RT_CDR;
                out_src     = OSRC_SAFE;
                core_in_src = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R4: modes hold through instruction shifts
    p_mode_hold_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_ir && shift_en && !update_en) |=> ($stable(out_src) && $stable(core_safe)
                                                && $stable(core_in_src)));

    // R4: data-path activity never changes the mode
    p_mode_hold_dr_r4: assert property (@(posedge tck) disable iff (!rst_n)
        !sel_ir |=> $stable(state));

    // R8: clamp keeps the boundary update stage frozen
    p_clamp_frozen_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (state == M_CLAMP) |-> (!bnd_upd_ok && route == RT_BYP));

endmodule

// File: rtl/core_wrap_ctrl.sv
module core_wrap_ctrl
    import wrap_ctl_pkg::*;
#(
    parameter int unsigned IR_W = 3
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       sel_ir,
    input  logic       shift_en,
    input  logic       capture_en,
    input  logic       update_en,
    input  logic       si,
    output logic       so,
    input  logic       bnd_so,
    input  logic       cdr_so,
    output logic       bnd_shift,
    output logic       bnd_capture,
    output logic       bnd_update,
    output logic       cdr_shift,
    output logic       cdr_capture,
    output logic       cdr_update,
    output logic [1:0] out_src,
    output logic       core_in_src,
    output logic       core_safe
);

    generate
        if (IR_W < 3) begin : g_bad_width
            initial $error("IR_W must be at least 3");
        end
    endgenerate

    logic [IR_W-1:0] ir_sr;
    logic            ir_lsb;
    logic            byp_q;
    logic            dr_path;
    logic            bnd_sel;
    logic            cdr_sel;
    logic            bnd_upd_ok;
    wmode_e          state;
    route_e          route;

    assign dr_path = !sel_ir;

    wrap_ir_reg #(.IR_W(IR_W)) u_ir (
        .tck        (tck),
        .rst_n      (rst_n),
        .sel_ir     (sel_ir),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .si         (si),
        .sr_q       (ir_sr),
        .sr_lsb     (ir_lsb)
    );

    wrap_bypass_reg u_byp (
        .tck        (tck),
        .rst_n      (rst_n),
        .dr_path    (dr_path),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .si         (si),
        .q          (byp_q)
    );

    wrap_mode_fsm #(.IR_W(IR_W)) u_fsm (
        .tck         (tck),
        .rst_n       (rst_n),
        .sel_ir      (sel_ir),
        .update_en   (update_en),
        .shift_en    (shift_en),
        .code        (ir_sr),
        .state       (state),
        .route       (route),
        .out_src     (out_src),
        .core_in_src (core_in_src),
        .core_safe   (core_safe),
        .bnd_upd_ok  (bnd_upd_ok)
    );

    assign bnd_sel = dr_path && (route == RT_BND);
    assign cdr_sel = dr_path && (route == RT_CDR);

    assign bnd_shift   = bnd_sel && shift_en;
    assign bnd_capture = bnd_sel && capture_en;
    assign bnd_update  = bnd_sel && bnd_upd_ok && update_en;
    assign cdr_shift   = cdr_sel && shift_en;
    assign cdr_capture = cdr_sel && capture_en;
    assign cdr_update  = cdr_sel && update_en;

    always_comb begin
        if (sel_ir) begin
            so = ir_lsb;
        end else begin
            unique case (route)
                RT_BND:  so = bnd_so;
                RT_CDR:  so = cdr_so;
                default: so = byp_q;
            endcase
        end
    end

    // R12: no data-register operation on the instruction path
    p_no_dr_ops_r12: assert property (@(posedge tck) disable iff (!rst_n)
        sel_ir |-> !(bnd_shift || bnd_capture || bnd_update
                     || cdr_shift || cdr_capture || cdr_update));

    // R12: the two external registers are never both enabled
    p_single_dr_r12: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bnd_shift || bnd_capture || bnd_update,
                  cdr_shift || cdr_capture || cdr_update}));

    // R9: safe-state outputs never take boundary data
    p_safe_no_bnd_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (out_src == 2'b10 && !core_in_src) |-> !(bnd_shift || bnd_update || bnd_capture));

endmodule

// File: tb/core_wrap_ctrl_bench.sv
module core_wrap_ctrl_bench;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic sel_ir = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic si = 1'b0, bnd_so = 1'b0, cdr_so = 1'b0;
    logic so, bnd_shift, bnd_capture, bnd_update, cdr_shift, cdr_capture, cdr_update;
    logic [1:0] out_src;
    logic core_in_src, core_safe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 tck = ~tck;

    core_wrap_ctrl u_core_wrap_ctrl (
        .tck(tck), .rst_n(rst_n), .sel_ir(sel_ir), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .si(si), .so(so),
        .bnd_so(bnd_so), .cdr_so(cdr_so), .bnd_shift(bnd_shift),
        .bnd_capture(bnd_capture), .bnd_update(bnd_update), .cdr_shift(cdr_shift),
        .cdr_capture(cdr_capture), .cdr_update(cdr_update), .out_src(out_src),
        .core_in_src(core_in_src), .core_safe(core_safe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // expected per code: route 0 bypass,1 boundary,2 core reg; out src; core in; safe
    int e_route, e_osrc, e_cin, e_safe;
    string e_req;
    task automatic expect_for(input int c);
        e_route = 0; e_osrc = 0; e_cin = 0; e_safe = 0;
        case (c)
            1: begin e_route = 1; e_osrc = 1; e_safe = 1; e_req = "R6"; end
            2: begin e_route = 1; e_req = "R7"; end
            3: begin e_osrc = 1; e_safe = 1; e_req = "R8"; end
            4: begin e_osrc = 2; e_safe = 1; e_req = "R9"; end
            5: begin e_route = 2; e_osrc = 2; e_cin = 1; e_req = "R10"; end
            default: e_req = "R11";
        endcase
    endtask

    int cur_code = 0;

    task automatic check_modes(input string req, input int c);
        expect_for(c);
        chk({req, " out_src"}, int'(out_src), e_osrc);
        chk({req, " core_in_src"}, int'(core_in_src), e_cin);
        chk({req, " core_safe"}, int'(core_safe), e_safe);
    endtask

    // capture, shift in new code LSB first, then update
    task automatic load_code(input int c);
        sel_ir = 1'b1; capture_en = 1'b1; shift_en = 1'b0; update_en = 1'b0;
        step();
        capture_en = 1'b0;
        check_modes("R4 capture", cur_code);
        for (int b = 0; b < 3; b++) begin
            shift_en = 1'b1;
            si = c[b];
            chk("R3 captured bit", int'(so), (b == 0) ? 1 : 0);
            chk("R12 enables on IR path", int'({bnd_shift, cdr_shift}), 0);
            step();
            check_modes("R4 shift", cur_code);
        end
        shift_en = 1'b0; update_en = 1'b1;
        chk("R12 update on IR path", int'({bnd_update, cdr_update}), 0);
        step();
        update_en = 1'b0; sel_ir = 1'b0;
        cur_code = c;
    endtask

    task automatic probe_data_path(input int c);
        int expv;
        expect_for(c);
        check_modes(e_req, c);
        sel_ir = 1'b0;
        // clear bypass bit
        si = 1'b0; shift_en = 1'b1;
        step();
        shift_en = 1'b0;
        bnd_so = 1'b1; cdr_so = 1'b0; #1;
        expv = (e_route == 1) ? 1 : 0;
        chk({e_req, " so route a"}, int'(so), expv);
        bnd_so = 1'b0; cdr_so = 1'b1; #1;
        expv = (e_route == 2) ? 1 : 0;
        chk({e_req, " so route b"}, int'(so), expv);
        // bypass holds 1, both returns 0
        bnd_so = 1'b0; cdr_so = 1'b0; si = 1'b1; shift_en = 1'b1;
        step();
        shift_en = 1'b0; si = 1'b0; #1;
        expv = (e_route == 0) ? 1 : 0;
        chk({e_req, " R5 bypass shift"}, int'(so), expv);
        // enables, one at a time (no clock edge needed for comb gating)
        shift_en = 1'b1; #1;
        chk({e_req, " bnd_shift"}, int'(bnd_shift), (e_route == 1) ? 1 : 0);
        chk({e_req, " cdr_shift"}, int'(cdr_shift), (e_route == 2) ? 1 : 0);
        shift_en = 1'b0; update_en = 1'b1; #1;
        chk({e_req, " bnd_update"}, int'(bnd_update), (e_route == 1) ? 1 : 0);
        chk({e_req, " cdr_update"}, int'(cdr_update), (e_route == 2) ? 1 : 0);
        update_en = 1'b0; capture_en = 1'b1; #1;
        chk({e_req, " bnd_capture"}, int'(bnd_capture), (e_route == 1) ? 1 : 0);
        chk({e_req, " cdr_capture"}, int'(cdr_capture), (e_route == 2) ? 1 : 0);
        step();
        capture_en = 1'b0; #1;
        if (e_route == 0) chk("R5 bypass capture zero", int'(so), 0);
        check_modes("R4 data ops", c);
    endtask

    initial begin
        // R1 reset state
        #12;
        check_modes("R1 in reset", 0);
        rst_n = 1'b1;
        step();
        check_modes("R1 after release", 0);
        chk("R1 so bypass", int'(so), 0);

        // R2 shift-through delay of 3 with sel_ir high
        begin
            logic [11:0] pat = 12'b1011_0011_1010;
            logic [11:0] seen;
            sel_ir = 1'b1; shift_en = 1'b1;
            for (int i = 0; i < 12; i++) begin
                si = pat[i];
                seen[i] = so;
                step();
            end
            shift_en = 1'b0; sel_ir = 1'b0;
            for (int i = 3; i < 12; i++)
                chk("R2 shift delay", int'(seen[i]), int'(pat[i-3]));
            check_modes("R4 long shift", 0);
        end

        // R12 with sel_ir high all enables high
        sel_ir = 1'b1; shift_en = 1'b1; capture_en = 1'b1; #1;
        chk("R12 all enables", int'({bnd_shift, bnd_capture, cdr_shift, cdr_capture}), 0);
        shift_en = 1'b0; capture_en = 1'b0; sel_ir = 1'b0;
        step();

        // sweep all codes, twice in different order
        for (int c = 0; c < 8; c++) begin
            load_code(c);
            probe_data_path(c);
        end
        for (int c = 7; c >= 0; c--) begin
            load_code((c * 3) % 8);
            probe_data_path((c * 3) % 8);
        end

        // R1 reset mid-operation returns to bypass
        load_code(4);
        rst_n = 1'b0; #2;
        check_modes("R1 async reset", 0);
        rst_n = 1'b1;
        step();
        cur_code = 0;
        probe_data_path(0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge tck);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule